// File: doc/BRIEF.md
# Closed-Loop Voltage and Frequency Step Controller

This controller moves a processor core between performance levels without ever letting the core clock run faster than its supply can sustain. It holds a supply voltage code that goes out to an external regulator and a level selection that drives the core clock. It also drives a test clock selection and enable toward an on-chip delay monitor, which answers with a single go/no-go bit.

When a higher level is requested, the core stays on its present clock. The monitor is run at the requested level while the voltage code climbs one step at a time, and each step is given a settle interval. Only a pass from the monitor moves the core to the new level. A lower level is applied to the core at once. After that, the voltage code is probed downward against the monitor and left at the lowest code that still passes. In a timer-only mode the monitor is bypassed: the code jumps to its upper limit and a fixed delay expires before the core is switched up.

A request that arrives while a transition is running is held and served afterwards. A fresh request replaces any older one still waiting.

Top module: `vfc_ctrl`

## Requirements
- R1: After reset `cur_level` is 0, `vcode` equals `vcode_max`, and `test_en`, `busy` and `err_flag` are all 0.
- R2: A request for the level already in `cur_level` leaves `cur_level` and `vcode` unchanged.
- R3: In closed-loop mode an upward request keeps `cur_level` at the old level, with `test_en` high and `test_sel` equal to the requested level, until `mon_pass` has been sampled high. Only then does `cur_level` take the new level and `test_en` fall.
- R4: In closed-loop mode `vcode` moves by at most one code per change. `mon_pass` is sampled only after `vcode` and `test_sel` have been stable for `settle_cycles` full cycles. An upward move ends with `vcode` equal to the larger of its starting value and the lowest passing code.
- R5: If an upward move reaches `vcode_max` without a pass, `err_flag` is set and stays set until reset. `cur_level` keeps the old level, `test_en` falls and `vcode` stays at `vcode_max`.
- R6: In closed-loop mode a downward request sets `cur_level` to the new level one cycle after the request is taken, before `vcode` changes. `vcode` then steps down while the monitor passes and the code is above `vcode_min`. On the first fail it steps back up by one. The result is the larger of the lowest passing code and `vcode_min`.
- R7: In open-loop mode (`open_loop` = 1) an upward request sets `vcode` to `vcode_max`. The request is sampled at clock edge 0, and `cur_level` changes at edge `ol_delay`+2 and not before. `test_en` stays low.
- R8: In open-loop mode a downward request changes `cur_level` at once and leaves `vcode` unchanged.
- R9: A request that arrives while `busy` is high is held and served when the running transition ends. If several arrive, only the latest is served.
- R10: `vcode` stays within [`vcode_min`, `vcode_max`], and whenever `test_en` is high, `test_sel` is at least `cur_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_loop | input | 1 | 1 selects the timer-only mode |
| vcode_min | input | VC_W | Lowest allowed voltage code |
| vcode_max | input | VC_W | Highest allowed voltage code |
| settle_cycles | input | SETTLE_W | Wait after each voltage or test-level change |
| ol_delay | input | OLD_W | Open-loop delay before an upward switch |
| req_valid | input | 1 | One-cycle strobe for a new level request |
| req_level | input | LVL_W | Requested performance level |
| mon_pass | input | 1 | Monitor go/no-go result at the test level |
| cur_level | output | LVL_W | Level applied to the core clock |
| test_sel | output | LVL_W | Level applied to the monitor test clock |
| test_en | output | 1 | Monitor test run enable |
| vcode | output | VC_W | Voltage code to the regulator |
| busy | output | 1 | Transition running or request waiting |
| err_flag | output | 1 | Sticky flag: upward move failed at the upper limit |

## Verification
The closed-loop path is swept over every ordered pair of three reachable levels, so that upward moves starting above and below the passing code, downward trims ending on a passing code, and trims stopped by the lower limit are all exercised. The bench's monitor model passes only after the code has been stable for the settle interval, so a sequencer that samples early ends on a different code. Open-loop moves are timed to the exact edge. A burst of two requests during a long climb separates latest-wins holding from first-wins holding. A level beyond the upper code limit exercises the sticky failure.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_UP_WAIT = 2'd1,
    ST_DN_WAIT = 2'd2,
    ST_OL_WAIT = 2'd3
  } vfc_state_t;
endpackage

// File: rtl/vfc_req_hold.sv
module vfc_req_hold #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             take,
  output logic             pend_valid,
  output logic [LVL_W-1:0] pend_level
);
  // Newest request wins; a strobe in the cycle of a take keeps the slot full.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_level <= '0;
    end else if (req_valid) begin
      pend_valid <= 1'b1;
      pend_level <= req_level;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vfc_countdown.sv
module vfc_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/vfc_seq.sv
module vfc_seq
  import vfc_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int VC_W     = 7,
  parameter int SETTLE_W = 8,
  parameter int OLD_W    = 16,
  parameter int TMR_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                open_loop,
  input  logic [VC_W-1:0]     vcode_min,
  input  logic [VC_W-1:0]     vcode_max,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [OLD_W-1:0]    ol_delay,
  input  logic                pend_valid,
  input  logic [LVL_W-1:0]    pend_level,
  input  logic                mon_pass,
  input  logic                tmr_zero,
  output logic                take,
  output logic                tmr_load,
  output logic [TMR_W-1:0]    tmr_val,
  output logic                tmr_dec,
  output logic [LVL_W-1:0]    cur_level,
  output logic [LVL_W-1:0]    test_sel,
  output logic                test_en,
  output logic [VC_W-1:0]     vcode,
  output logic                err_flag,
  output logic                in_flight
);
  vfc_state_t       state;
  logic [LVL_W-1:0] tgt;

  logic going_up, going_dn;
  assign take     = (state == ST_IDLE) && pend_valid;
  assign going_up = pend_level > cur_level;
  assign going_dn = pend_level < cur_level;

  // Timer control: reload on entry to a wait or after each voltage step.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(settle_cycles);
    tmr_dec  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (take && going_up && open_loop) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ol_delay);
        end else if (take && !open_loop && (going_up || going_dn)) begin
          tmr_load = 1'b1;
        end
      end
      ST_UP_WAIT: begin
        if (!tmr_zero) tmr_dec = 1'b1;
        else if (!mon_pass && vcode < vcode_max) tmr_load = 1'b1;
      end
      ST_DN_WAIT: begin
        if (!tmr_zero) tmr_dec = 1'b1;
        else if (mon_pass && vcode > vcode_min) tmr_load = 1'b1;
      end
      default: begin
        if (!tmr_zero) tmr_dec = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tgt       <= '0;
      cur_level <= '0;
      test_sel  <= '0;
      test_en   <= 1'b0;
      vcode     <= vcode_max;
      err_flag  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            tgt <= pend_level;
            if (going_up) begin
              if (open_loop) begin
                vcode <= vcode_max;
                state <= ST_OL_WAIT;
              end else begin
                test_sel <= pend_level;
                test_en  <= 1'b1;
                state    <= ST_UP_WAIT;
              end
            end else if (going_dn) begin
              cur_level <= pend_level;
              if (!open_loop) begin
                test_sel <= pend_level;
                test_en  <= 1'b1;
                state    <= ST_DN_WAIT;
              end
            end
          end
        end
        ST_UP_WAIT: begin
          if (tmr_zero) begin
            if (mon_pass) begin
              cur_level <= tgt;
              test_en   <= 1'b0;
              state     <= ST_IDLE;
            end else if (vcode >= vcode_max) begin
              err_flag <= 1'b1;
              test_en  <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              vcode <= vcode + 1'b1;
            end
          end
        end
        ST_DN_WAIT: begin
          if (tmr_zero) begin
            if (!mon_pass) begin
              vcode   <= vcode + 1'b1;
              test_en <= 1'b0;
              state   <= ST_IDLE;
            end else if (vcode <= vcode_min) begin
              test_en <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              vcode <= vcode - 1'b1;
            end
          end
        end
        default: begin
          if (tmr_zero) begin
            cur_level <= tgt;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign in_flight = (state != ST_IDLE);
endmodule

// File: rtl/vfc_ctrl.sv
module vfc_ctrl #(
  parameter int LVL_W    = 3,
  parameter int VC_W     = 7,
  parameter int SETTLE_W = 8,
  parameter int OLD_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                open_loop,
  input  logic [VC_W-1:0]     vcode_min,
  input  logic [VC_W-1:0]     vcode_max,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [OLD_W-1:0]    ol_delay,
  input  logic                req_valid,
  input  logic [LVL_W-1:0]    req_level,
  input  logic                mon_pass,
  output logic [LVL_W-1:0]    cur_level,
  output logic [LVL_W-1:0]    test_sel,
  output logic                test_en,
  output logic [VC_W-1:0]     vcode,
  output logic                busy,
  output logic                err_flag
);
  localparam int TMR_W = (SETTLE_W > OLD_W) ? SETTLE_W : OLD_W;

  logic             pend_valid;
  logic [LVL_W-1:0] pend_level;
  logic             take;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             in_flight;

  vfc_req_hold #(.LVL_W(LVL_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_level (pend_level)
  );

  vfc_countdown #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  vfc_seq #(
    .LVL_W(LVL_W), .VC_W(VC_W), .SETTLE_W(SETTLE_W),
    .OLD_W(OLD_W), .TMR_W(TMR_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .open_loop     (open_loop),
    .vcode_min     (vcode_min),
    .vcode_max     (vcode_max),
    .settle_cycles (settle_cycles),
    .ol_delay      (ol_delay),
    .pend_valid    (pend_valid),
    .pend_level    (pend_level),
    .mon_pass      (mon_pass),
    .tmr_zero      (tmr_zero),
    .take          (take),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .tmr_dec       (tmr_dec),
    .cur_level     (cur_level),
    .test_sel      (test_sel),
    .test_en       (test_en),
    .vcode         (vcode),
    .err_flag      (err_flag),
    .in_flight     (in_flight)
  );

  assign busy = in_flight | pend_valid;
endmodule

// File: rtl/vfc_ctrl_chk.sv
module vfc_ctrl_chk #(
  parameter int LVL_W = 3,
  parameter int VC_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             open_loop,
  input logic [VC_W-1:0]  vcode_min,
  input logic [VC_W-1:0]  vcode_max,
  input logic             mon_pass,
  input logic [LVL_W-1:0] cur_level,
  input logic [LVL_W-1:0] test_sel,
  input logic             test_en,
  input logic [VC_W-1:0]  vcode,
  input logic             err_flag
);
  // R3: a closed-loop rise of the core level needs a pass in the deciding cycle
  a_r3_rise_after_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(open_loop) && cur_level > $past(cur_level)) |-> $past(mon_pass));

  // R4: closed-loop voltage moves one code at a time
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    !$past(open_loop) |-> (vcode == $past(vcode) ||
                           vcode == $past(vcode) + 1'b1 ||
                           vcode + 1'b1 == $past(vcode)));

  // R5: the failure flag never clears outside reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(err_flag) |-> err_flag);

  // R8: open-loop downward switch leaves the voltage alone
  a_r8_ol_down_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(open_loop) && cur_level < $past(cur_level)) |-> vcode == $past(vcode));

  // R10: voltage code within limits
  a_r10_vcode_range: assert property (@(posedge clk) disable iff (rst)
    (vcode >= vcode_min) && (vcode <= vcode_max));

  // R10: the monitor is never tested below the core level
  a_r10_test_not_below: assert property (@(posedge clk) disable iff (rst)
    test_en |-> test_sel >= cur_level);
endmodule

bind vfc_ctrl vfc_ctrl_chk #(.LVL_W(LVL_W), .VC_W(VC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .open_loop (open_loop),
  .vcode_min (vcode_min),
  .vcode_max (vcode_max),
  .mon_pass  (mon_pass),
  .cur_level (cur_level),
  .test_sel  (test_sel),
  .test_en   (test_en),
  .vcode     (vcode),
  .err_flag  (err_flag)
);

// File: tb/vfc_ctrl_tb.sv
module vfc_ctrl_tb;
  localparam int LVL_W = 2;
  localparam int VC_W  = 7;
  localparam int SW    = 8;
  localparam int OW    = 16;
  localparam int VMIN  = 35;
  localparam int VMAX  = 55;
  localparam int SETTLE = 3;
  localparam int OLDLY  = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             open_loop = 1'b0;
  logic             req_valid = 1'b0;
  logic [LVL_W-1:0] req_level = '0;
  logic             mon_pass = 1'b0;
  logic [LVL_W-1:0] cur_level, test_sel;
  logic             test_en, busy, err_flag;
  logic [VC_W-1:0]  vcode;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_v   = VMAX;
  int exp_lvl = 0;

  always #5 clk = ~clk;

  vfc_ctrl #(.LVL_W(LVL_W), .VC_W(VC_W), .SETTLE_W(SW), .OLD_W(OW)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .open_loop     (open_loop),
    .vcode_min     (VC_W'(VMIN)),
    .vcode_max     (VC_W'(VMAX)),
    .settle_cycles (SW'(SETTLE)),
    .ol_delay      (OW'(OLDLY)),
    .req_valid     (req_valid),
    .req_level     (req_level),
    .mon_pass      (mon_pass),
    .cur_level     (cur_level),
    .test_sel      (test_sel),
    .test_en       (test_en),
    .vcode         (vcode),
    .busy          (busy),
    .err_flag      (err_flag)
  );

  function automatic int thr(input int lvl);
    return 30 + 10 * lvl;
  endfunction

  // Monitor model: passes once the code reaches the level threshold and
  // code and test level have both held for SETTLE cycles.
  int          stable_cnt = 0;
  logic [VC_W-1:0]  last_v = '0;
  logic [LVL_W-1:0] last_s = '0;
  always @(negedge clk) begin
    if (vcode !== last_v || test_sel !== last_s) stable_cnt = 0;
    else stable_cnt = stable_cnt + 1;
    last_v = vcode;
    last_s = test_sel;
    mon_pass = (int'(vcode) >= thr(int'(test_sel))) && (stable_cnt >= SETTLE);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse_req(input int lvl);
    req_level = LVL_W'(lvl);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Closed-loop move with model update and checks.
  task automatic cl_move(input int lvl);
    int from = exp_lvl;
    pulse_req(lvl);
    @(negedge clk);
    if (lvl > from) begin
      chk(cur_level == LVL_W'(from) && test_en && test_sel == LVL_W'(lvl),
          "R3 hold old level while testing", int'(cur_level), from);
      if (thr(lvl) <= VMAX) begin
        exp_v = (exp_v > thr(lvl)) ? exp_v : thr(lvl);
        exp_lvl = lvl;
      end else begin
        exp_v = VMAX;
      end
    end else if (lvl < from) begin
      chk(cur_level == LVL_W'(lvl) && int'(vcode) == exp_v,
          "R6 frequency lowered first", int'(cur_level), lvl);
      exp_v = (thr(lvl) > VMIN) ? thr(lvl) : VMIN;
      exp_lvl = lvl;
    end
    wait_idle();
    if (lvl == from)
      chk(cur_level == LVL_W'(from) && int'(vcode) == exp_v,
          "R2 same level ignored", int'(vcode), exp_v);
    chk(cur_level == LVL_W'(exp_lvl), "R3/R6 final level", int'(cur_level), exp_lvl);
    chk(int'(vcode) == exp_v, "R4/R6 final voltage code", int'(vcode), exp_v);
    chk(!test_en, "R3 test run ended", int'(test_en), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cur_level == '0, "R1 reset level", int'(cur_level), 0);
    chk(int'(vcode) == VMAX, "R1 reset voltage", int'(vcode), VMAX);
    chk(!test_en && !busy && !err_flag, "R1 reset flags",
        int'({test_en, busy, err_flag}), 0);

    // R2 at reset level, then near-exhaustive sweep of closed-loop pairs (R3, R4, R6)
    cl_move(0);
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        cl_move(a);
        cl_move(b);
      end
    end

    // R9: two requests during a long climb, the latest wins
    cl_move(0);
    pulse_req(2);
    repeat (3) @(negedge clk);
    chk(busy, "R9 busy during climb", int'(busy), 1);
    pulse_req(1);
    @(negedge clk);
    pulse_req(0);
    wait_idle();
    chk(cur_level == 2'd0, "R9 latest request served", int'(cur_level), 0);
    chk(int'(vcode) == VMIN, "R9 voltage after held request", int'(vcode), VMIN);
    exp_v = VMIN; exp_lvl = 0;

    // R7: open-loop upward with exact timing
    open_loop = 1'b1;
    @(negedge clk);
    req_level = 2'd2;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (OLDLY + 1) @(negedge clk);
    chk(cur_level == 2'd0, "R7 no early switch", int'(cur_level), 0);
    chk(int'(vcode) == VMAX && !test_en, "R7 voltage at max, no test", int'(vcode), VMAX);
    @(negedge clk);
    chk(cur_level == 2'd2, "R7 switch at delay", int'(cur_level), 2);
    wait_idle();

    // R8: open-loop downward keeps voltage
    pulse_req(1);
    @(negedge clk);
    chk(cur_level == 2'd1, "R8 immediate switch", int'(cur_level), 1);
    wait_idle();
    chk(int'(vcode) == VMAX, "R8 voltage unchanged", int'(vcode), VMAX);
    open_loop = 1'b0;
    exp_v = VMAX; exp_lvl = 1;
    cl_move(0);

    // R5: level above the code range fails and sticks
    chk(!err_flag, "R5 no error yet", int'(err_flag), 0);
    cl_move(3);
    chk(err_flag, "R5 error set", int'(err_flag), 1);
    chk(cur_level == 2'd0, "R5 level kept", int'(cur_level), 0);
    cl_move(1);
    chk(err_flag, "R5 error sticky", int'(err_flag), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule